// File: doc/BRIEF.md
# Nibble-serial indirect register command interface

This block sits on the slave side of a byte-wide host command bus. Each host write is either a command address write, which selects a command register, or a data write, which carries four bits of that register's value in its low nibble. Two consecutive data writes form one byte, upper nibble first. The bus is narrow, but the block gives the host access to a 16-bit extended register space through an indirect window. One command address loads the low byte of the extended address. A second loads the high byte. A third takes the value byte.

When the lower nibble of a value byte arrives, the block writes the whole byte into the extended register that the two latched address bytes select. For one cycle after that it reports busy and refuses data writes. The host can read the selected extended register back through a read strobe. A single-bit change is therefore done as a read-modify-write. A small bank of sample extended registers is implemented. Every other extended address ignores writes and reads as zero.

Top module: `nibble_cmd_regs`

## Requirements
- R1: After reset, busy_o is 0, rdata_o is 0x00, both latched address bytes are 0x00 and every implemented extended register holds 0x00.
- R2: A byte is built from two data writes (wr_en_i=1, cmd_sel_i=0). The first write supplies bits 7:4 from its wdata_i[3:0]. The second supplies bits 3:0 from its wdata_i[3:0]. wdata_i[7:4] of a data write is ignored.
- R3: A completed byte under command address 0x3A loads the low extended address byte. A completed byte under 0x3B loads the high extended address byte. The extended address is {high, low}.
- R4: A completed byte under command address 0x3C is written to the extended register at the latched address in the cycle of its lower nibble. After only the upper nibble, the register is unchanged.
- R5: A command address write (wr_en_i=1, cmd_sel_i=1) discards any pending upper nibble, so the next data write is taken as a new upper nibble.
- R6: rdata_o loads the byte of the extended register at the latched address at the clock edge where rd_en_i is 1. It holds its value at every other edge.
- R7: Implemented extended registers are at addresses 0xE608 to 0xE60B. A write to any other address changes no register, and a read from any other address returns 0x00.
- R8: busy_o is 1 for exactly the one cycle after each commit. A data write sampled in that cycle is rejected and does not take part in nibble assembly.
- R9: Completed bytes under command addresses other than 0x3A, 0x3B and 0x3C change neither the latched address nor any register.
- R10: A commit replaces all eight bits of the target register, so a read, a bit change and a write-back leave every other bit as read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe, one transfer per cycle |
| cmd_sel_i | input | 1 | 1: command address write, 0: nibble data write |
| wdata_i | input | 8 | Write data (command address, or nibble in bits 3:0) |
| rd_en_i | input | 1 | Read strobe for the selected extended register |
| rdata_o | output | 8 | Registered read data |
| busy_o | output | 1 | High for the cycle after a commit |

## Verification
The bench sends a lone upper nibble and then a fresh command address. A design that kept the stale nibble would commit a byte built from the wrong halves and leave a nibble pending. It also places a data write in the busy cycle straight after a commit. A design that accepted that write would shift every later nibble by one and store a byte from mismatched halves. Writes to addresses next to the implemented range must not alias onto it. A write under a foreign command address, or a change of only the low address byte, must not disturb the other latched byte or any register.

// File: rtl/nci_pkg.sv
package nci_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned NIB_W    = DATA_W / 2;
  localparam int unsigned EADDR_W  = 2 * DATA_W;

  localparam logic [DATA_W-1:0] CMD_ADDR_LO = 8'h3A;
  localparam logic [DATA_W-1:0] CMD_ADDR_HI = 8'h3B;
  localparam logic [DATA_W-1:0] CMD_VALUE   = 8'h3C;
endpackage

// File: rtl/nci_nibble_seq.sv
module nci_nibble_seq #(
  parameter int unsigned DW = 8,
  localparam int unsigned NW = DW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          cmd_sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  output logic          byte_vld_o,
  output logic [DW-1:0] byte_o,
  output logic [DW-1:0] cmd_o
);
  logic [DW-1:0] cmd_q;
  logic [NW-1:0] hi_nib_q;
  logic          hi_pend_q;
  logic          data_wr;
  logic          unused_hi;

  assign data_wr   = wr_en_i && !cmd_sel_i && !busy_i;
  assign unused_hi = ^wdata_i[DW-1:NW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      hi_nib_q  <= '0;
      hi_pend_q <= 1'b0;
    end else if (wr_en_i && cmd_sel_i) begin
      cmd_q     <= wdata_i;
      hi_pend_q <= 1'b0;
    end else if (data_wr) begin
      if (!hi_pend_q) hi_nib_q <= wdata_i[NW-1:0];
      hi_pend_q <= !hi_pend_q;
    end
  end

  assign byte_vld_o = data_wr && hi_pend_q;
  assign byte_o     = {hi_nib_q, wdata_i[NW-1:0]};
  assign cmd_o      = cmd_q;

  // R5
  cmd_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && cmd_sel_i) |=> !hi_pend_q);

  // R8
  busy_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_en_i && !cmd_sel_i) |=> ($stable(hi_pend_q) && $stable(hi_nib_q)));
endmodule

// File: rtl/nci_addr_win.sv
module nci_addr_win
  import nci_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned AW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic [DW-1:0] cmd_i,
  output logic [AW-1:0] ext_addr_o,
  output logic          commit_o,
  output logic [DW-1:0] commit_data_o,
  output logic          busy_o
);
  logic [DW-1:0] lo_q, hi_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (byte_vld_i) begin
      if (cmd_i == CMD_ADDR_LO) lo_q <= byte_i;
      if (cmd_i == CMD_ADDR_HI) hi_q <= byte_i;
    end
  end

  assign commit_o      = byte_vld_i && (cmd_i == CMD_VALUE);
  assign commit_data_o = byte_i;
  assign ext_addr_o    = {hi_q, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= commit_o;
  end
  assign busy_o = busy_q;

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_i |=> $stable(ext_addr_o));

  // R8
  busy_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !busy_q);
endmodule

// File: rtl/nci_ext_regfile.sv
module nci_ext_regfile #(
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 16,
  parameter int unsigned NUM_REGS = 4,
  parameter logic [AW-1:0] BASE   = 16'hE608
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0]       regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] hit;
  logic [DW-1:0]       rd_mux;
  logic [DW-1:0]       rdata_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [AW-1:0] REG_ADDR = BASE + AW'(i);
    assign hit[i] = (addr_i == REG_ADDR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              regs_q[i] <= '0;
      else if (we_i && hit[i])  regs_q[i] <= wdata_i;
    end

    // R7
    reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && hit[i]) |=> $stable(regs_q[i]));
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (hit[i]) rd_mux = rd_mux | regs_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  // R7
  hit_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));

  // R6
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/nibble_cmd_regs.sv
module nibble_cmd_regs
  import nci_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter logic [EADDR_W-1:0] REG_BASE = 16'hE608
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              cmd_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o
);
  logic               byte_vld;
  logic [DATA_W-1:0]  byte_val;
  logic [DATA_W-1:0]  cmd;
  logic [EADDR_W-1:0] ext_addr;
  logic               commit;
  logic [DATA_W-1:0]  commit_data;
  logic               busy;

  nci_nibble_seq #(.DW(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .cmd_sel_i  (cmd_sel_i),
    .wdata_i    (wdata_i),
    .busy_i     (busy),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_val),
    .cmd_o      (cmd)
  );

  nci_addr_win #(.DW(DATA_W)) u_win (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .byte_vld_i    (byte_vld),
    .byte_i        (byte_val),
    .cmd_i         (cmd),
    .ext_addr_o    (ext_addr),
    .commit_o      (commit),
    .commit_data_o (commit_data),
    .busy_o        (busy)
  );

  nci_ext_regfile #(
    .DW(DATA_W), .AW(EADDR_W), .NUM_REGS(NUM_REGS), .BASE(REG_BASE)
  ) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (commit),
    .addr_i  (ext_addr),
    .wdata_i (commit_data),
    .rd_en_i (rd_en_i),
    .rdata_o (rdata_o)
  );

  assign busy_o = busy;

  // R8
  busy_after_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> busy_o);
endmodule

// File: tb/tb_nibble_cmd_regs.sv
module tb_nibble_cmd_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {lo, hi, value, unused}
  localparam logic [31:0] VEC [NV] = '{
    32'h08E61C00, 32'h09E6A500, 32'h0AE63F00, 32'h0BE6C000,
    32'h0CE67700, 32'h08E75500, 32'h08E6F000, 32'h07E61200
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0, cmd_sel = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic busy;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_cmd_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .cmd_sel_i(cmd_sel),
    .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata), .busy_o(busy)
  );

  function automatic logic [7:0] exp_read(logic [15:0] a, logic [7:0] v);
    return (a >= 16'hE608 && a <= 16'hE60B) ? v : 8'h00;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic sel, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; cmd_sel = sel; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_byte(logic [7:0] c, logic [7:0] v);
    bus_wr(1'b1, c);
    bus_wr(1'b0, {4'h0, v[7:4]});
    bus_wr(1'b0, {4'h0, v[3:0]});
  endtask

  task automatic ext_write(logic [15:0] a, logic [7:0] v);
    write_byte(8'h3A, a[7:0]);
    write_byte(8'h3B, a[15:8]);
    write_byte(8'h3C, v);
  endtask

  task automatic ext_read(output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", {7'b0, busy}, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    rst_ni = 1'b1;
    ext_read(d);
    check("R1 addr 0000 reads 0", d, 8'h00);
    write_byte(8'h3A, 8'h08);
    write_byte(8'h3B, 8'hE6);
    ext_read(d);
    check("R1 reg E608 reset", d, 8'h00);

    // R3 R4 R7 table walk
    for (int i = 0; i < NV; i++) begin
      logic [15:0] a;
      a = {VEC[i][23:16], VEC[i][31:24]};
      ext_write(a, VEC[i][15:8]);
      ext_read(d);
      check("R3/R4/R7 table", d, exp_read(a, VEC[i][15:8]));
    end
    // R7 neighbours not aliased by unimplemented writes
    ext_write(16'hE609, 8'h00); // set addr only via full write
    ext_write(16'hE609, 8'hA5);
    write_byte(8'h3A, 8'h08);
    ext_read(d);
    check("R7 E608 intact", d, 8'hF0);
    write_byte(8'h3A, 8'h0B);
    ext_read(d);
    check("R7/R3 E60B intact via low byte only", d, 8'hC0);

    // R6 rdata holds without rd_en
    write_byte(8'h3A, 8'h08);
    @(negedge clk);
    check("R6 rdata hold", rdata, 8'hC0);

    // R8 busy and rejection
    write_byte(8'h3A, 8'h0A);
    write_byte(8'h3B, 8'hE6);
    bus_wr(1'b1, 8'h3C);
    bus_wr(1'b0, 8'h01);
    check("R8 busy idle", {7'b0, busy}, 8'h00);
    @(negedge clk);
    wr_en = 1'b1; cmd_sel = 1'b0; wdata = 8'h0C;
    @(negedge clk);
    check("R8 busy after commit", {7'b0, busy}, 8'h01);
    wdata = 8'h05;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 busy one cycle", {7'b0, busy}, 8'h00);
    ext_read(d);
    check("R8 committed 1C", d, 8'h1C);
    bus_wr(1'b0, 8'h07);
    bus_wr(1'b0, 8'h08);
    ext_read(d);
    check("R8 rejected nibble", d, 8'h78);

    // R4 upper nibble alone; R5 restart
    ext_write(16'hE609, 8'h66);
    bus_wr(1'b1, 8'h3C);
    bus_wr(1'b0, 8'h03);
    ext_read(d);
    check("R4 no commit on upper", d, 8'h66);
    bus_wr(1'b1, 8'h3C);
    bus_wr(1'b0, 8'h04);
    bus_wr(1'b0, 8'h02);
    ext_read(d);
    check("R5 pending discarded", d, 8'h42);

    // R9 foreign command address
    write_byte(8'h20, 8'hE6);
    write_byte(8'h3D, 8'h99);
    ext_read(d);
    check("R9 foreign cmd", d, 8'h42);

    // R2 upper bits of data writes ignored
    write_byte(8'h3A, 8'h0B);
    bus_wr(1'b1, 8'h3C);
    bus_wr(1'b0, 8'hF3);
    bus_wr(1'b0, 8'hA9);
    ext_read(d);
    check("R2 nibble assembly", d, 8'h39);

    // R10 read-modify-write
    ext_read(d);
    d = d | 8'h80;
    write_byte(8'h3C, d);
    ext_read(d);
    check("R10 rmw", d, 8'hB9);
    write_byte(8'h3A, 8'h0A);
    ext_read(d);
    check("R10 neighbour", d, 8'h78);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule